// File: doc/BRIEF.md
# Configurable Cartridge Bank Address Mapper

The mapper turns a console CPU program address (the upper half of the 16-bit space, split into four 8 KB windows) and a video pattern address (the low 8 KB of the video space, split into eight 1 KB windows) into wide physical bank numbers. It uses a classic command/data bank-switching scheme. Around that scheme sit an outer base taken from an extended register file, a program bank mask set by a shift amount, and a video write mask that can be forced down to four bits. Together these let one large memory hold many small games, each confined to its own slice.

Writes arrive on one port as an address, a data byte and a strobe. Three address regions are decoded. A sixteen-entry extended block at 0x4100-0x410F is written directly. Two aliases in the 0x20xx region reach the video-base and control registers. The 0x8000-0xEFFF range carries the command/data pair and the mirroring control. The outputs are combinational functions of the registered state: four program bank numbers, eight video bank numbers and a mirroring bit. No write path has a bypass, so a write shows up at the outputs from the clock edge that captures it.

Top module: `bank_mapper`

## Requirements
- R1: A write to 0x4100+N (N = 0..15) stores the data byte into extended register N.
- R2: A write to 0x2018 loads extended register 12 (video base) and a write to 0x201A loads extended register 13 (control). Other 0x20xx addresses, for example 0x2019, change nothing.
- R3: In 0x8000-0xEFFF the decode uses address bits 15, 14, 13 and 0. Even 0x8000 stores the command into register 15. Odd 0x8000 is the data port. Even 0xA000 sets mirror_o to the inverse of data bit 0. All other decodes (odd 0xA000, 0xC000, 0xE000) and any address at 0xF000 or above change nothing.
- R4: A data write with command (register 15 bits 2:0) 0..5 stores into video register [cmd]. The value is masked with 0x0F when register 13 bit 2 is set, and with 0xFF shifted right by register 11 bits 7:4 otherwise.
- R5: A data write with command 6 or 7 uses the mask 0x3F shifted right by register 11 bits 3:0. Only the masked bits of register cmd+1 (7 or 8) are replaced; the other bits keep their value.
- R6: A program bank number is 12 bits: bits 11:8 are register 0 bits 7:4. The low byte is (selector AND mask) OR (register 10 AND NOT mask), where the mask is the R5 mask. Window 0 (0x8000) selects with register 7 and window 1 (0xA000) with register 8.
- R7: With register 13 bit 1 clear, window 2 selects with 0xFE and window 3 selects with 0xFF, both through the R6 composition.
- R8: With register 13 bit 1 set, window 2 selects with register 9 through the R6 composition, and window 3 takes register 10 in full.
- R9: When register 13 bit 0 and register 15 bit 6 are both set, windows 0 and 2 exchange their bank numbers.
- R10: A video bank number is 16 bits. It is base OR inner, with base = (({reg0[3:0],8'h00}) OR (reg12 shifted left by 1) OR reg13[7:3]) shifted left by 3. The inner values of slots 0..7 are v0&0xFE, v0|1, v1&0xFE, v1|1, v2, v3, v4, v5. When register 15 bit 7 is set, slot s takes the inner value of slot s XOR 4.
- R11: After reset every register is zero except register 9 (0x3E) and register 10 (0x3F), all video registers are zero, and mirror_o is 0.
- R12: Bank outputs reflect a write in the cycle that follows the capturing clock edge, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_bank_o | output | 48 | Four 12-bit program bank numbers; window w at bits [w*12 +: 12], w=0 is 0x8000 |
| chr_bank_o | output | 128 | Eight 16-bit video bank numbers; slot s at bits [s*16 +: 16], s=0 is 0x0000 |
| mirror_o | output | 1 | Nametable mirroring select |

## Verification
The write sequences first move the outer base alone, then the inner selectors alone. This separates faults in the base bits from faults in the mask composition. Partial writes go to program registers that already hold ones outside the mask, which exposes any write that replaces the whole byte. The fixed-tail and free-tail program modes are then run with and without the window swap, and the video path is run with both mask sources and both window orders. Writes to neighbouring addresses that must be ignored are each followed by a full compare of every output, so a stray decode appears as a changed bank.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 16;
  localparam int EXT_N   = 16;
  localparam int VB_N    = 6;
  localparam int PRG_WIN = 4;
  localparam int CHR_WIN = 8;
  localparam int PRG_W   = DATA_W + 4;
  localparam int CHR_W   = 2 * DATA_W;
  localparam int IDX_W   = $clog2(EXT_N);

  localparam int REG_OUTER = 0;
  localparam int REG_SEL0  = 7;
  localparam int REG_SEL1  = 8;
  localparam int REG_SEL2  = 9;
  localparam int REG_TAIL  = 10;
  localparam int REG_SHIFT = 11;
  localparam int REG_VBASE = 12;
  localparam int REG_CTRL  = 13;
  localparam int REG_MIRR  = 14;
  localparam int REG_CMD   = 15;

  localparam logic [ADDR_W-1:0] EXT_BASE = 16'h4100;
  localparam logic [ADDR_W-1:0] ALIAS_VB = 16'h2018;
  localparam logic [ADDR_W-1:0] ALIAS_CT = 16'h201A;

  function automatic logic [DATA_W-1:0] ext_reset_val(input int idx);
    if (idx == REG_SEL2) return 8'h3E;
    if (idx == REG_TAIL) return 8'h3F;
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] prg_mask(input logic [3:0] sh);
    return 8'h3F >> sh;
  endfunction

  function automatic logic [DATA_W-1:0] chr_wr_mask(input logic nib_only, input logic [3:0] sh);
    return nib_only ? 8'h0F : (8'hFF >> sh);
  endfunction

  function automatic logic [DATA_W-1:0] merge_bits(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic [PRG_W-1:0] prg_window(input logic [3:0] outer,
                                                  input logic [DATA_W-1:0] sel,
                                                  input logic [DATA_W-1:0] tail,
                                                  input logic [DATA_W-1:0] pm);
    return {outer, merge_bits(tail, sel, pm)};
  endfunction

  function automatic logic [CHR_W-1:0] chr_base(input logic [3:0] lo,
                                                input logic [DATA_W-1:0] vbase,
                                                input logic [4:0] ctl_hi);
    logic [12:0] t;
    t = {lo, 8'h00} | {4'h0, vbase, 1'b0} | {8'h00, ctl_hi};
    return {t, 3'b000};
  endfunction
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_map_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [EXT_N-1:0][DATA_W-1:0]  ext_q,
  output logic [VB_N-1:0][DATA_W-1:0]   vb_q
);
  logic       hit_ext, hit_alias_vb, hit_alias_ct, in_bank;
  logic       hit_cmd, hit_data, hit_mirror, hit_vb, hit_pb;
  logic [2:0] sel, cmd;
  logic [3:0] pb_idx;
  logic [DATA_W-1:0] vb_mask, pb_mask;

  assign hit_ext      = wr_en && (wr_addr[ADDR_W-1:IDX_W] == EXT_BASE[ADDR_W-1:IDX_W]);
  assign hit_alias_vb = wr_en && (wr_addr == ALIAS_VB);
  assign hit_alias_ct = wr_en && (wr_addr == ALIAS_CT);
  assign in_bank      = wr_en && wr_addr[15] && (wr_addr[14:12] != 3'b111);
  assign sel          = {wr_addr[14:13], wr_addr[0]};
  assign hit_cmd      = in_bank && (sel == 3'b000);
  assign hit_data     = in_bank && (sel == 3'b001);
  assign hit_mirror   = in_bank && (sel == 3'b010);
  assign cmd          = ext_q[REG_CMD][2:0];
  assign hit_vb       = hit_data && (cmd < 3'd6);
  assign hit_pb       = hit_data && (cmd >= 3'd6);
  assign pb_idx       = {1'b0, cmd} + 4'd1;
  assign vb_mask      = chr_wr_mask(ext_q[REG_CTRL][2], ext_q[REG_SHIFT][7:4]);
  assign pb_mask      = prg_mask(ext_q[REG_SHIFT][3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < EXT_N; i++) ext_q[i] <= ext_reset_val(i);
      for (int j = 0; j < VB_N; j++) vb_q[j] <= '0;
    end else if (hit_ext) begin
      ext_q[wr_addr[IDX_W-1:0]] <= wr_data;
    end else if (hit_alias_vb) begin
      ext_q[REG_VBASE] <= wr_data;
    end else if (hit_alias_ct) begin
      ext_q[REG_CTRL] <= wr_data;
    end else if (hit_cmd) begin
      ext_q[REG_CMD] <= wr_data;
    end else if (hit_mirror) begin
      ext_q[REG_MIRR] <= {{(DATA_W-1){1'b0}}, ~wr_data[0]};
    end else if (hit_pb) begin
      ext_q[pb_idx] <= merge_bits(ext_q[pb_idx], wr_data, pb_mask);
    end else if (hit_vb) begin
      vb_q[cmd] <= wr_data & vb_mask;
    end
  end

  AST_EXT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ext |=> ext_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)); // R1
  AST_ALIAS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_alias_ct |=> ext_q[REG_CTRL] == $past(wr_data)); // R2
  AST_MIRROR_INV: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mirror |=> ext_q[REG_MIRR][0] != $past(wr_data[0])); // R3
  AST_VB_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vb && ext_q[REG_CTRL][2]) |=> vb_q[$past(cmd)][7:4] == 4'h0); // R4
  AST_PB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pb |=> ((ext_q[$past(pb_idx)] ^ $past(ext_q[pb_idx])) & ~$past(pb_mask)) == '0); // R5
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import bank_map_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               outer,
  input  logic [DATA_W-1:0]        sel0,
  input  logic [DATA_W-1:0]        sel1,
  input  logic [DATA_W-1:0]        sel2,
  input  logic [DATA_W-1:0]        tail,
  input  logic [3:0]               shift,
  input  logic                     free_tail,
  input  logic                     swap_en,
  output logic [PRG_WIN*PRG_W-1:0] prg_bank_o
);
  logic [DATA_W-1:0] pm;
  logic [PRG_W-1:0]  src [PRG_WIN];

  assign pm     = prg_mask(shift);
  assign src[0] = prg_window(outer, sel0, tail, pm);
  assign src[1] = prg_window(outer, sel1, tail, pm);
  assign src[2] = free_tail ? prg_window(outer, sel2, tail, pm)
                            : prg_window(outer, 8'hFE, tail, pm);
  assign src[3] = free_tail ? {outer, tail}
                            : prg_window(outer, 8'hFF, tail, pm);

  for (genvar w = 0; w < PRG_WIN; w++) begin : g_win
    if ((w % 2) == 0) begin : g_swappable
      assign prg_bank_o[w*PRG_W +: PRG_W] = swap_en ? src[w ^ 2] : src[w];
    end else begin : g_fixed
      assign prg_bank_o[w*PRG_W +: PRG_W] = src[w];
    end
  end

  AST_TAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !free_tail |-> (prg_bank_o[3*PRG_W +: DATA_W] & pm) == pm); // R7
  AST_OUTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    prg_bank_o[PRG_W-1 -: 4] == prg_bank_o[2*PRG_W-1 -: 4]); // R6
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
  import bank_map_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [3:0]                   base_lo,
  input  logic [DATA_W-1:0]            vbase,
  input  logic [4:0]                   ctl_hi,
  input  logic                         swap_en,
  input  logic [VB_N-1:0][DATA_W-1:0]  vb,
  output logic [CHR_WIN*CHR_W-1:0]     chr_bank_o
);
  localparam int HALF = CHR_WIN / 2;
  logic [CHR_W-1:0]  cbase;
  logic [DATA_W-1:0] src [CHR_WIN];

  assign cbase = chr_base(base_lo, vbase, ctl_hi);

  for (genvar k = 0; k < CHR_WIN; k++) begin : g_src
    if (k < HALF) begin : g_pair
      assign src[k] = {vb[k/2][DATA_W-1:1], (k % 2) == 1};
    end else begin : g_single
      assign src[k] = vb[k-2];
    end
  end

  for (genvar s = 0; s < CHR_WIN; s++) begin : g_slot
    assign chr_bank_o[s*CHR_W +: CHR_W] =
      cbase | {{(CHR_W-DATA_W){1'b0}}, (swap_en ? src[s ^ HALF] : src[s])};
  end

  AST_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_en |-> chr_bank_o[CHR_W +: CHR_W] == (chr_bank_o[0 +: CHR_W] | 16'h0001)); // R10
  AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> chr_bank_o[5*CHR_W +: CHR_W] == (chr_bank_o[4*CHR_W +: CHR_W] | 16'h0001)); // R10
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [PRG_WIN*PRG_W-1:0] prg_bank_o,
  output logic [CHR_WIN*CHR_W-1:0] chr_bank_o,
  output logic                     mirror_o
);
  logic [EXT_N-1:0][DATA_W-1:0] ext_q;
  logic [VB_N-1:0][DATA_W-1:0]  vb_q;
  logic prg_swap, chr_swap, unused_bits;

  bank_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_q(ext_q), .vb_q(vb_q)
  );

  assign prg_swap = ext_q[REG_CTRL][0] & ext_q[REG_CMD][6];
  assign chr_swap = ext_q[REG_CMD][7];

  prg_window_map u_prg (
    .clk(clk), .rst_n(rst_n),
    .outer(ext_q[REG_OUTER][7:4]),
    .sel0(ext_q[REG_SEL0]), .sel1(ext_q[REG_SEL1]), .sel2(ext_q[REG_SEL2]),
    .tail(ext_q[REG_TAIL]), .shift(ext_q[REG_SHIFT][3:0]),
    .free_tail(ext_q[REG_CTRL][1]), .swap_en(prg_swap),
    .prg_bank_o(prg_bank_o)
  );

  chr_window_map u_chr (
    .clk(clk), .rst_n(rst_n),
    .base_lo(ext_q[REG_OUTER][3:0]), .vbase(ext_q[REG_VBASE]),
    .ctl_hi(ext_q[REG_CTRL][7:3]), .swap_en(chr_swap),
    .vb(vb_q), .chr_bank_o(chr_bank_o)
  );

  assign mirror_o = ext_q[REG_MIRR][0];

  assign unused_bits = ^{ext_q[1], ext_q[2], ext_q[3], ext_q[4], ext_q[5], ext_q[6],
                         ext_q[REG_SHIFT][7:4], ext_q[REG_CTRL][2],
                         ext_q[REG_MIRR][7:1], ext_q[REG_CMD][5:0]};

  AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == EXT_BASE) |=> prg_bank_o[PRG_W-1 -: 4] == $past(wr_data[7:4])); // R12
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [15:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [47:0]  prg_bank_o;
  logic [127:0] chr_bank_o;
  logic         mirror_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_ext [16];
  logic [7:0] m_vb  [6];

  logic [47:0]  q_prg [$];
  logic [127:0] q_chr [$];
  logic         q_mir [$];
  string        q_tag [$];

  always #10 clk = ~clk;

  bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prg_bank_o(prg_bank_o), .chr_bank_o(chr_bank_o),
    .mirror_o(mirror_o)
  );

  function automatic logic [11:0] m_prg_win(input int sel);
    int pm, inner, base;
    pm    = 63 >> (m_ext[11] % 16);
    inner = (sel & pm) + (m_ext[10] & (255 - pm));
    base  = (m_ext[0] / 16) * 256;
    return 12'(base + inner);
  endfunction

  function automatic logic [47:0] m_prg();
    logic [11:0] w [4];
    logic [11:0] t;
    w[0] = m_prg_win(m_ext[7]);
    w[1] = m_prg_win(m_ext[8]);
    if (m_ext[13][1]) begin
      w[2] = m_prg_win(m_ext[9]);
      w[3] = 12'((m_ext[0] / 16) * 256 + m_ext[10]);
    end else begin
      w[2] = m_prg_win(254);
      w[3] = m_prg_win(255);
    end
    if (m_ext[13][0] && m_ext[15][6]) begin
      t = w[0]; w[0] = w[2]; w[2] = t;
    end
    return {w[3], w[2], w[1], w[0]};
  endfunction

  function automatic logic [127:0] m_chr();
    int base;
    logic [7:0] inner [8];
    logic [127:0] r;
    base = (((m_ext[0] % 16) * 256) | (m_ext[12] * 2) | (m_ext[13] / 8)) * 8;
    for (int p = 0; p < 2; p++) begin
      inner[2*p]   = m_vb[p] & 8'hFE;
      inner[2*p+1] = m_vb[p] | 8'h01;
    end
    for (int k = 4; k < 8; k++) inner[k] = m_vb[k-2];
    for (int s = 0; s < 8; s++) begin
      int src;
      src = m_ext[15][7] ? ((s + 4) % 8) : s;
      r[s*16 +: 16] = 16'(base | inner[src]);
    end
    return r;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    int cmd, mk;
    if (a[15:4] == 12'h410) m_ext[a[3:0]] = d;
    else if (a == 16'h2018) m_ext[12] = d;
    else if (a == 16'h201A) m_ext[13] = d;
    else if (a >= 16'h8000 && a < 16'hF000) begin
      case ({a[14:13], a[0]})
        3'b000: m_ext[15] = d;
        3'b001: begin
          cmd = m_ext[15] % 8;
          if (cmd < 6) begin
            mk = m_ext[13][2] ? 15 : (255 >> (m_ext[11] / 16));
            m_vb[cmd] = d & 8'(mk);
          end else begin
            mk = 63 >> (m_ext[11] % 16);
            m_ext[cmd+1] = (m_ext[cmd+1] & ~8'(mk)) | (d & 8'(mk));
          end
        end
        3'b010: m_ext[14] = d[0] ? 8'h00 : 8'h01;
        default: ;
      endcase
    end
  endtask

  task automatic push_expect(input string tag);
    q_prg.push_back(m_prg());
    q_chr.push_back(m_chr());
    q_mir.push_back(m_ext[14][0]);
    q_tag.push_back(tag);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    push_expect(tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    logic [47:0]  ep;
    logic [127:0] ec;
    logic         em;
    string        tg;
    forever begin
      @(posedge clk);
      #5;
      if (q_tag.size() > 0) begin
        ep = q_prg.pop_front(); ec = q_chr.pop_front();
        em = q_mir.pop_front(); tg = q_tag.pop_front();
        checks += 3;
        if (prg_bank_o !== ep) begin
          errors++;
          $display("FAIL %s prg_bank actual=%h expected=%h", tg, prg_bank_o, ep);
        end
        if (chr_bank_o !== ec) begin
          errors++;
          $display("FAIL %s chr_bank actual=%h expected=%h", tg, chr_bank_o, ec);
        end
        if (mirror_o !== em) begin
          errors++;
          $display("FAIL %s mirror actual=%b expected=%b", tg, mirror_o, em);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 16; i++) m_ext[i] = (i == 9) ? 8'h3E : ((i == 10) ? 8'h3F : 8'h00);
    for (int i = 0; i < 6; i++) m_vb[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push_expect("R11 reset state");
    @(negedge clk);

    do_write(16'h4100, 8'h50, "R1 R6 outer base");
    do_write(16'h8000, 8'h06, "R3 command store");
    do_write(16'h8001, 8'h15, "R5 R6 sel0 full mask");
    do_write(16'h410B, 8'h02, "R1 R6 narrow mask");
    do_write(16'h4108, 8'hA0, "R1 sel1 preset");
    do_write(16'h8000, 8'h07, "R3 command 7");
    do_write(16'h8001, 8'h33, "R5 partial sel1");
    do_write(16'h410A, 8'hC5, "R6 R7 tail outer bits");
    do_write(16'h4109, 8'h12, "R1 sel2 direct");
    do_write(16'h201A, 8'h02, "R2 R8 free tail");
    do_write(16'h2019, 8'hFF, "R2 ignored alias");
    do_write(16'h201A, 8'h03, "R2 R8 swap enable only");
    do_write(16'h8000, 8'h46, "R9 program swap");
    do_write(16'h201A, 8'h01, "R7 R9 fixed tail swapped");
    do_write(16'h8000, 8'h00, "R3 command 0");
    do_write(16'h410B, 8'h00, "R1 full masks");
    do_write(16'h8001, 8'h37, "R4 R10 video pair 0");
    do_write(16'h410B, 8'h22, "R1 video shift");
    do_write(16'h8000, 8'h01, "R3 command 1");
    do_write(16'h8001, 8'hFF, "R4 shifted video mask");
    do_write(16'h201A, 8'h07, "R2 nibble mode");
    do_write(16'h8000, 8'h02, "R3 command 2");
    do_write(16'h8001, 8'hAB, "R4 nibble video mask");
    do_write(16'h8000, 8'h05, "R3 command 5");
    do_write(16'h8001, 8'h9C, "R4 last video reg");
    do_write(16'h2018, 8'h81, "R2 R10 video base");
    do_write(16'h4100, 8'h5A, "R10 video base low");
    do_write(16'h201A, 8'hF8, "R10 control high bits");
    do_write(16'h8000, 8'h85, "R10 video swap");
    do_write(16'hA000, 8'h00, "R3 mirror set");
    do_write(16'hA001, 8'h55, "R3 odd A000 ignored");
    do_write(16'hC000, 8'hFF, "R3 C000 ignored");
    do_write(16'hE001, 8'hFF, "R3 E001 ignored");
    do_write(16'hF000, 8'h40, "R3 F000 ignored");
    do_write(16'hA000, 8'h01, "R3 mirror clear");
    do_write(16'h4100, 8'hF0, "R12 next cycle update");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule